// File: doc/BRIEF.md
# Byte Stream to Word FIFO Packer

This block sits between a byte-wide data stream and a word-wide FIFO port that only accepts and returns whole 32-bit words, with the first byte of the stream in the most significant position. On the write side it gathers incoming bytes into words. Up to three leftover bytes stay in a spill register between bursts, so a later burst can complete the word. A flush request sends out a partial spill as one word, with the unused low byte positions filled with zeros.

On the read side it pops a whole word from the FIFO only when the consumer takes a byte and no bytes are held. It hands out the most significant byte at once and keeps the remaining bytes. A transfer-start pulse empties both spills and cancels a pending flush. Bytes of the last word that the consumer never took are therefore discarded.

The byte ports use valid/ready handshakes. The word ports use push/pop with full/empty flags. The FIFO is expected to show its head word on its read-data port whenever it is not empty.

Top module: `byte_word_adapter`

## Requirements
- R1: While reset is asserted and after it is released, no word is pushed or popped, `flush_busy` is low, and `wr_ready` is high while `xfer_start` is low.
- R2: A pushed word carries the four bytes it holds in big-endian order: the first byte accepted goes in bits 31:24 and the last in bits 7:0.
- R3: A word is pushed in the same cycle as the handshake of its fourth byte. Fewer than four bytes are held without a push, across any number of idle cycles between bursts.
- R4: `wr_ready` is high exactly when no flush is pending, `xfer_start` is low, and either fewer than three bytes are held or `fifo_full` is low. No push happens while `fifo_full` is high.
- R5: A `flush_req` pulse makes `flush_busy` high from the next cycle. While the FIFO is not full and bytes are held, the held bytes are pushed as one word with zeros in the unused low positions. `flush_busy` then drops in the following cycle, and `wr_ready` stays low while it is high.
- R6: A flush with no bytes held pushes no word, and `flush_busy` is high for exactly one cycle.
- R7: `rd_valid` is high when bytes are held or `fifo_empty` is low, provided `xfer_start` is low. `rd_data` is the oldest held byte, or else bits 31:24 of `fifo_rdata`. Bytes of one word come out from most to least significant.
- R8: No word is popped while `fifo_empty` is high.
- R9: In a cycle with `xfer_start` high, `wr_ready` and `rd_valid` are low. All held bytes in both directions are discarded and any pending flush is cancelled.
- R10: A word is popped only in a cycle in which a read byte is taken while no read bytes are held. Taking one to three bytes of a fresh transfer therefore pops exactly one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_start | input | 1 | Start of a transfer: clears both spills and any pending flush |
| wr_valid | input | 1 | Write byte valid |
| wr_data | input | 8 | Write byte |
| wr_ready | output | 1 | Write byte accepted when high together with `wr_valid` |
| flush_req | input | 1 | Request to emit the partial write spill |
| flush_busy | output | 1 | Flush pending |
| fifo_push | output | 1 | Push one word into the FIFO |
| fifo_wdata | output | 32 | Word to push, big-endian |
| fifo_full | input | 1 | FIFO cannot accept a word |
| rd_valid | output | 1 | Read byte valid |
| rd_data | output | 8 | Read byte |
| rd_ready | input | 1 | Consumer takes the read byte |
| fifo_pop | output | 1 | Pop the head word from the FIFO |
| fifo_rdata | input | 32 | Head word of the FIFO |
| fifo_empty | input | 1 | FIFO holds no word |

## Verification
The embedded properties watch the FIFO-side safety rules on every cycle: no push into a full FIFO, no pop from an empty one, and a pop only when a byte is taken. They also check that a byte-less push happens only during a flush, that a pop leaves a byte available next cycle, and that a start cancels the flush. Byte ordering, zero padding, the carry of a partial tail across idle gaps, and the loss of surplus read bytes at a new transfer depend on data history. Only the bench's reference model can show these, with the write and read paths looped through a shallow model FIFO under directed and randomized traffic.

// File: rtl/bwa_pkg.sv
package bwa_pkg;

  localparam int unsigned BYTE_W_DEF = 8;
  localparam int unsigned LANES_DEF  = 4;

  // Bit position of the least significant bit of byte lane `lane`, where
  // lane 0 is the most significant byte of the word.
  function automatic int unsigned lane_lsb(input int unsigned lane,
                                           input int unsigned lanes,
                                           input int unsigned bw);
    return (lanes - 1 - lane) * bw;
  endfunction

endpackage

// File: rtl/bwa_packer.sv
module bwa_packer #(
  parameter int unsigned BYTE_W = bwa_pkg::BYTE_W_DEF,
  parameter int unsigned LANES  = bwa_pkg::LANES_DEF
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      in_valid,
  input  logic [BYTE_W-1:0]         in_data,
  output logic                      in_ready,
  input  logic                      flush_req,
  output logic                      flush_busy,
  output logic                      push,
  output logic [BYTE_W*LANES-1:0]   wdata,
  input  logic                      full
);

  localparam int unsigned WORD_W = BYTE_W * LANES;
  localparam int unsigned HOLD   = LANES - 1;
  localparam int unsigned CW     = $clog2(LANES);

  logic [BYTE_W-1:0] hold_q [HOLD];
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              pend_q, pend_d;
  logic              last_slot, acc, word_push, flush_push, flush_done;
  logic [HOLD-1:0]   slot_we;

  assign last_slot  = (cnt_q == CW'(HOLD));
  assign in_ready   = !pend_q && !start && (!last_slot || !full);
  assign acc        = in_valid && in_ready;
  assign word_push  = acc && last_slot;
  assign flush_push = pend_q && !start && (cnt_q != '0) && !full;
  assign flush_done = pend_q && ((cnt_q == '0) || !full);
  assign push       = word_push || flush_push;
  assign flush_busy = pend_q;

  // Word assembly: held lanes below the count, the incoming byte in the
  // last lane on a full word, zeros elsewhere.
  generate
    for (genvar i = 0; i < HOLD; i++) begin : g_lane
      assign wdata[bwa_pkg::lane_lsb(i, LANES, BYTE_W) +: BYTE_W] =
        (CW'(i) < cnt_q) ? hold_q[i] : '0;
      assign slot_we[i] = acc && !last_slot && (cnt_q == CW'(i));
    end
  endgenerate
  assign wdata[BYTE_W-1:0] = word_push ? in_data : '0;

  always_comb begin
    cnt_d  = cnt_q;
    pend_d = (pend_q && !flush_done) || flush_req;
    if (start) begin
      cnt_d  = '0;
      pend_d = 1'b0;
    end else if (word_push || flush_done) begin
      cnt_d = '0;
    end else if (acc) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < HOLD; i++) hold_q[i] <= '0;
    end else begin
      for (int i = 0; i < HOLD; i++)
        if (slot_we[i]) hold_q[i] <= in_data;
    end
  end

  // R4
  no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R5
  flush_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !(in_valid && in_ready)) |-> flush_busy);

  // R9
  start_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !flush_busy);

endmodule

// File: rtl/bwa_unpacker.sv
module bwa_unpacker #(
  parameter int unsigned BYTE_W = bwa_pkg::BYTE_W_DEF,
  parameter int unsigned LANES  = bwa_pkg::LANES_DEF
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  output logic                      out_valid,
  output logic [BYTE_W-1:0]         out_data,
  input  logic                      out_ready,
  output logic                      pop,
  input  logic [BYTE_W*LANES-1:0]   rdata,
  input  logic                      empty
);

  localparam int unsigned HOLD = LANES - 1;
  localparam int unsigned CW   = $clog2(LANES);

  logic [BYTE_W-1:0] hold_q [HOLD];
  logic [BYTE_W-1:0] hold_d [HOLD];
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              held, take, shift;

  assign held      = (cnt_q != '0);
  assign out_valid = !start && (held || !empty);
  assign out_data  = held ? hold_q[0]
                          : rdata[bwa_pkg::lane_lsb(0, LANES, BYTE_W) +: BYTE_W];
  assign take      = out_valid && out_ready;
  assign pop       = take && !held;
  assign shift     = take && held;

  // Refill from lanes 1.. of the popped word, or shift toward slot 0.
  generate
    for (genvar i = 0; i < HOLD; i++) begin : g_slot
      if (i < HOLD - 1) begin : g_mid
        assign hold_d[i] = pop   ? rdata[bwa_pkg::lane_lsb(i + 1, LANES, BYTE_W) +: BYTE_W]
                         : shift ? hold_q[i + 1] : hold_q[i];
      end else begin : g_end
        assign hold_d[i] = pop ? rdata[bwa_pkg::lane_lsb(i + 1, LANES, BYTE_W) +: BYTE_W]
                               : hold_q[i];
      end
    end
  endgenerate

  always_comb begin
    cnt_d = cnt_q;
    if (start)      cnt_d = '0;
    else if (pop)   cnt_d = CW'(HOLD);
    else if (shift) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < HOLD; i++) hold_q[i] <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (pop || shift)
        for (int i = 0; i < HOLD; i++) hold_q[i] <= hold_d[i];
    end
  end

  // R8
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

  // R10
  pop_demand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (out_valid && out_ready));

  // R7
  pop_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> (start || out_valid));

endmodule

// File: rtl/byte_word_adapter.sv
module byte_word_adapter #(
  parameter int unsigned BYTE_W = bwa_pkg::BYTE_W_DEF,
  parameter int unsigned LANES  = bwa_pkg::LANES_DEF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    xfer_start,
  input  logic                    wr_valid,
  input  logic [BYTE_W-1:0]       wr_data,
  output logic                    wr_ready,
  input  logic                    flush_req,
  output logic                    flush_busy,
  output logic                    fifo_push,
  output logic [BYTE_W*LANES-1:0] fifo_wdata,
  input  logic                    fifo_full,
  output logic                    rd_valid,
  output logic [BYTE_W-1:0]       rd_data,
  input  logic                    rd_ready,
  output logic                    fifo_pop,
  input  logic [BYTE_W*LANES-1:0] fifo_rdata,
  input  logic                    fifo_empty
);

  bwa_packer #(.BYTE_W(BYTE_W), .LANES(LANES)) u_pack (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (xfer_start),
    .in_valid   (wr_valid),
    .in_data    (wr_data),
    .in_ready   (wr_ready),
    .flush_req  (flush_req),
    .flush_busy (flush_busy),
    .push       (fifo_push),
    .wdata      (fifo_wdata),
    .full       (fifo_full)
  );

  bwa_unpacker #(.BYTE_W(BYTE_W), .LANES(LANES)) u_unpack (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (xfer_start),
    .out_valid (rd_valid),
    .out_data  (rd_data),
    .out_ready (rd_ready),
    .pop       (fifo_pop),
    .rdata     (fifo_rdata),
    .empty     (fifo_empty)
  );

endmodule

// File: tb/byte_word_adapter_test.sv
module byte_word_adapter_test;

  localparam int FQ_DEPTH = 4;

  logic        clk, rst_n;
  logic        xfer_start, wr_valid, flush_req, rd_ready;
  logic [7:0]  wr_data;
  logic        wr_ready, flush_busy, fifo_push, rd_valid, fifo_pop;
  logic [31:0] fifo_wdata, fifo_rdata;
  logic [7:0]  rd_data;
  logic        fifo_full, fifo_empty;

  int tests = 0;
  int fails = 0;
  int push_cnt = 0;
  int pop_cnt = 0;
  logic [31:0] last_w;
  logic [7:0]  last_rd;

  // Reference model state
  logic [7:0]  wsp[$];
  logic [7:0]  rsp[$];
  logic [31:0] fq[$];
  bit          pend = 0;

  byte_word_adapter uut (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .flush_req(flush_req), .flush_busy(flush_busy),
    .fifo_push(fifo_push), .fifo_wdata(fifo_wdata), .fifo_full(fifo_full),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_ready(rd_ready),
    .fifo_pop(fifo_pop), .fifo_rdata(fifo_rdata), .fifo_empty(fifo_empty)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pad_word();
    logic [31:0] w = '0;
    for (int i = 0; i < 4; i++)
      w = (w << 8) | ((i < wsp.size()) ? 32'(wsp[i]) : 32'd0);
    return w;
  endfunction

  task automatic step(input bit st, input bit wv, input logic [7:0] wb,
                      input bit fl, input bit rr);
    bit          ff, fe, exp_ready, acc, exp_push, exp_valid, take, exp_pop, done;
    logic [31:0] exp_w, head;
    logic [7:0]  exp_byte;
    @(negedge clk);
    xfer_start = st; wr_valid = wv; wr_data = wb; flush_req = fl; rd_ready = rr;
    ff = (fq.size() >= FQ_DEPTH);
    fe = (fq.size() == 0);
    head = fe ? 32'd0 : fq[0];
    fifo_full = ff; fifo_empty = fe; fifo_rdata = head;
    #1;
    exp_ready = !pend && !st && (wsp.size() < 3 || !ff);
    acc = wv && exp_ready;
    exp_push = 0; exp_w = '0;
    if (!st) begin
      if (acc && wsp.size() == 3) begin
        exp_push = 1; exp_w = {wsp[0], wsp[1], wsp[2], wb};
      end else if (pend && wsp.size() > 0 && !ff) begin
        exp_push = 1; exp_w = pad_word();
      end
    end
    exp_valid = !st && (rsp.size() > 0 || !fe);
    exp_byte  = (rsp.size() > 0) ? rsp[0] : head[31:24];
    take      = exp_valid && rr;
    exp_pop   = take && (rsp.size() == 0);

    chk(wr_ready == exp_ready, "R4", "wr_ready", 32'(wr_ready), 32'(exp_ready));
    chk(fifo_push == exp_push, "R3", "fifo_push", 32'(fifo_push), 32'(exp_push));
    if (exp_push && fifo_push)
      chk(fifo_wdata == exp_w, "R2", "fifo_wdata", fifo_wdata, exp_w);
    chk(flush_busy == pend, "R5", "flush_busy", 32'(flush_busy), 32'(pend));
    chk(rd_valid == exp_valid, "R7", "rd_valid", 32'(rd_valid), 32'(exp_valid));
    if (exp_valid)
      chk(rd_data == exp_byte, "R7", "rd_data", 32'(rd_data), 32'(exp_byte));
    chk(fifo_pop == exp_pop, "R10", "fifo_pop", 32'(fifo_pop), 32'(exp_pop));
    if (fifo_pop && fe)
      chk(1'b0, "R8", "pop while empty", 32'(fifo_pop), 32'd0);
    if (st)
      chk(!wr_ready && !rd_valid, "R9", "ready/valid in start cycle",
          {30'd0, wr_ready, rd_valid}, 32'd0);
    if (fifo_push) begin push_cnt++; last_w = fifo_wdata; end
    if (fifo_pop) pop_cnt++;
    if (rd_valid && rr) last_rd = rd_data;

    @(posedge clk);
    if (st) begin
      wsp.delete(); rsp.delete(); pend = 0;
    end else begin
      done = pend && (wsp.size() == 0 || !ff);
      if (acc) begin
        if (wsp.size() == 3) wsp.delete();
        else wsp.push_back(wb);
      end
      if (done) wsp.delete();
      pend = (pend && !done) || fl;
      if (take) begin
        if (rsp.size() > 0) void'(rsp.pop_front());
        else begin
          rsp.push_back(head[23:16]); rsp.push_back(head[15:8]); rsp.push_back(head[7:0]);
        end
      end
    end
    if (exp_pop) void'(fq.pop_front());
    if (exp_push) fq.push_back(exp_w);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 8'h00, 0, 0);
  endtask

  initial begin
    int p;
    rst_n = 1'b0;
    xfer_start = 0; wr_valid = 0; wr_data = '0; flush_req = 0; rd_ready = 0;
    fifo_full = 0; fifo_empty = 1; fifo_rdata = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!fifo_push && !fifo_pop, "R1", "push/pop in reset", {30'd0, fifo_push, fifo_pop}, 32'd0);
    chk(!flush_busy, "R1", "flush_busy in reset", 32'(flush_busy), 32'd0);
    chk(wr_ready, "R1", "wr_ready in reset", 32'(wr_ready), 32'd1);
    chk(!rd_valid, "R1", "rd_valid in reset", 32'(rd_valid), 32'd0);
    rst_n = 1'b1;
    idle(2);

    // R2, R3: six bytes over two bursts with a gap
    for (int i = 1; i <= 4; i++) step(0, 1, 8'(i), 0, 0);
    chk(push_cnt == 1, "R3", "push count after 4 bytes", 32'(push_cnt), 32'd1);
    chk(last_w == 32'h01020304, "R2", "first word", last_w, 32'h01020304);
    step(0, 1, 8'h05, 0, 0);
    idle(5);
    step(0, 1, 8'h06, 0, 0);
    idle(3);
    chk(push_cnt == 1, "R3", "partial tail held", 32'(push_cnt), 32'd1);
    // R5: flush of two held bytes
    step(0, 0, 8'h00, 1, 0);
    idle(3);
    chk(push_cnt == 2, "R5", "flush push count", 32'(push_cnt), 32'd2);
    chk(last_w == 32'h05060000, "R5", "zero padded word", last_w, 32'h05060000);

    // R6: flush with empty spill
    p = push_cnt;
    step(0, 0, 8'h00, 1, 0);
    chk(!fifo_push, "R6", "no push in request cycle", 32'(fifo_push), 32'd0);
    step(0, 0, 8'h00, 0, 0);
    chk(flush_busy, "R6", "busy one cycle", 32'(flush_busy), 32'd1);
    step(0, 0, 8'h00, 0, 0);
    chk(!flush_busy, "R6", "busy cleared", 32'(flush_busy), 32'd0);
    chk(push_cnt == p, "R6", "no word pushed", 32'(push_cnt), 32'(p));

    // R7, R10: read five bytes from two words
    p = pop_cnt;
    for (int i = 0; i < 5; i++) step(0, 0, 8'h00, 0, 1);
    chk(pop_cnt == p + 2, "R10", "pops for five bytes", 32'(pop_cnt), 32'(p + 2));
    chk(last_rd == 8'h05, "R7", "fifth byte", 32'(last_rd), 32'h05);
    // R9: start discards the three surplus bytes
    step(1, 0, 8'h00, 0, 0);
    step(0, 0, 8'h00, 0, 0);
    chk(!rd_valid, "R9", "surplus read bytes discarded", 32'(rd_valid), 32'd0);

    // R10, R9: partial read of a fresh transfer
    for (int i = 0; i < 8; i++) step(0, 1, 8'h10 + 8'(i), 0, 0);
    step(1, 0, 8'h00, 0, 0);
    p = pop_cnt;
    step(0, 0, 8'h00, 0, 1);
    step(0, 0, 8'h00, 0, 1);
    chk(pop_cnt == p + 1, "R10", "one pop for two bytes", 32'(pop_cnt), 32'(p + 1));
    step(1, 0, 8'h00, 0, 0);
    step(0, 0, 8'h00, 0, 1);
    chk(last_rd == 8'h14, "R9", "new transfer starts at next word", 32'(last_rd), 32'h14);
    chk(pop_cnt == p + 2, "R10", "pop for new transfer", 32'(pop_cnt), 32'(p + 2));

    // R4: write pressure with no reads, then a flush into a full FIFO
    for (int i = 0; i < 30; i++) step(0, 1, 8'(8'h40 + i), 0, 0);
    step(0, 0, 8'h00, 1, 0);
    for (int i = 0; i < 12; i++) step(0, 0, 8'h00, 0, 1);
    step(1, 0, 8'h00, 0, 0);

    // Mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      bit st = ($urandom_range(0, 99) < 2);
      bit wv = ($urandom_range(0, 99) < 60);
      bit fl = ($urandom_range(0, 99) < 6);
      bit rr = ($urandom_range(0, 99) < ((i / 500) % 2 ? 80 : 30));
      step(st, wv, 8'($urandom), fl, rr);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule